// File: doc/BRIEF.md
# Power and Clock State Controller

This block sequences the power state of a chip and, for a set of internal modules, drives clock enables, power enables, isolation controls and resets, along with the enable of the reference clock oscillator. It runs entirely on the slow internal sleep clock. Each managed module raises a sleep request. When all of them that are not masked agree, the controller drops into a sleep state, turns the reference clock off and ramps the module domain down one step per cycle.

Leaving sleep, or leaving the host-off state, always passes through a wake state. The wake state lasts for a number of sleep-clock cycles taken from an input, which gives the reference clock time to settle. The domain then powers back up in the reverse order. A host-off input and a global power-off input force their states directly. The off state can only be left through the asynchronous power-on reset. The current state is visible on a 3-bit code.

Top module: `pwr_state_ctl`

## Requirements
- R1: The `stateCode` output encodes OFF=0, HOST_OFF=1, SLEEP=2, WAKEUP=3 and ON=4. While `rstPorN` is low the state is WAKEUP. After release the state stays in WAKEUP for `PorWake` cycles (default 8) and then enters ON.
- R2: `refClkEn` is high in WAKEUP and ON and low in OFF, HOST_OFF and SLEEP.
- R3: ON moves to SLEEP when every `sleepReq` bit whose `sleepMask` bit is 0 is high and `wakeIn` is low. A request bit whose mask bit is 1 has no effect on entry to or exit from SLEEP.
- R4: SLEEP moves to WAKEUP when any unmasked `sleepReq` bit is low or `wakeIn` is high.
- R5: On each entry to WAKEUP the value of `wakeDelay` is captured. The state then stays in WAKEUP for exactly that many cycles before entering ON, and a value of 0 counts as 1. ON is never entered from any state other than WAKEUP.
- R6: While `hostOff` is high, the state is HOST_OFF unless it is OFF. When `hostOff` drops in HOST_OFF, the state moves to WAKEUP.
- R7: `powerOff` forces OFF and has priority over every other input. OFF is left only through `rstPorN`.
- R8: In any state other than ON, the module domain steps down one stage per cycle: first reset asserts (`modRstN` low), then isolation turns on, then the clock is gated, then power is removed. All modules' outputs move together.
- R9: In ON, the domain steps up one stage per cycle: power on, then clock on, then isolation off, and reset is released one cycle after isolation drops. A change of state mid-ramp reverses the direction from the stage already reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkSleep | input | 1 | Slow sleep clock |
| rstPorN | input | 1 | Asynchronous power-on reset, active low |
| sleepReq | input | NumMod | Per-module sleep request |
| sleepMask | input | NumMod | 1 excludes the module's request from the sleep decision |
| wakeIn | input | 1 | Wake event, blocks or ends SLEEP |
| hostOff | input | 1 | Forces HOST_OFF |
| powerOff | input | 1 | Forces OFF |
| wakeDelay | input | WakeW | WAKEUP length in sleep-clock cycles |
| refClkEn | output | 1 | Reference clock oscillator enable |
| modClkEn | output | NumMod | Module clock enables |
| modPwrEn | output | NumMod | Module power enables |
| modIso | output | NumMod | Module isolation controls, 1 isolates |
| modRstN | output | NumMod | Module resets, active low |
| stateCode | output | 3 | Current power state |

## Verification
A wrong state register shows on `stateCode` and `refClkEn` in the same cycle it is taken. A wrong domain stage shows on the module enables at the next edge, because each stage is exactly one output pattern. A wake counter that is loaded or decremented wrongly shows only at the end of WAKEUP, as ON entered early or late. For this reason, every wake scenario is followed cycle by cycle until the domain is fully up.

// File: rtl/pwrctl_pkg.sv
package pwrctl_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_HOSTOFF = 3'd1,
    ST_SLEEP   = 3'd2,
    ST_WAKE    = 3'd3,
    ST_ON      = 3'd4
  } pwrState_e;

  typedef struct packed {
    logic loadWake;   // capture wake length this edge
    logic countWake;  // decrement wake counter
    logic rampUp;     // domain steps up (else down)
  } ctlStrobe_t;

  // domain stages: 0 off, 1 power, 2 clock, 3 isolation off, 4 reset released
  localparam int unsigned LVL_TOP = 4;
endpackage

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwrctl_pkg::*;
#(
  parameter int NumMod = 3
) (
  input  logic              clkSleep,
  input  logic              rstPorN,
  input  logic [NumMod-1:0] sleepReq,
  input  logic [NumMod-1:0] sleepMask,
  input  logic              wakeIn,
  input  logic              hostOff,
  input  logic              powerOff,
  input  logic              wakeDone,
  output pwrState_e         state,
  output ctlStrobe_t        strobe
);
  pwrState_e nxt;
  logic allAsleep;

  always_comb allAsleep = &(sleepReq | sleepMask);

  always_comb begin
    nxt = state;
    if (powerOff) begin
      nxt = ST_OFF;
    end else if (hostOff && state != ST_OFF) begin
      nxt = ST_HOSTOFF;
    end else begin
      unique case (state)
        ST_OFF:     nxt = ST_OFF;
        ST_HOSTOFF: nxt = ST_WAKE;
        ST_SLEEP:   if (!allAsleep || wakeIn) nxt = ST_WAKE;
        ST_WAKE:    if (wakeDone) nxt = ST_ON;
        ST_ON:      if (allAsleep && !wakeIn) nxt = ST_SLEEP;
        default:    nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clkSleep or negedge rstPorN) begin
    if (!rstPorN) state <= ST_WAKE;
    else          state <= nxt;
  end

  always_comb begin
    strobe.loadWake  = (nxt == ST_WAKE) && (state != ST_WAKE);
    strobe.countWake = (state == ST_WAKE);
    strobe.rampUp    = (state == ST_ON);
  end
endmodule

// File: rtl/pwr_domain_dp.sv
module pwr_domain_dp
  import pwrctl_pkg::*;
#(
  parameter int NumMod  = 3,
  parameter int WakeW   = 16,
  parameter int PorWake = 8
) (
  input  logic              clkSleep,
  input  logic              rstPorN,
  input  ctlStrobe_t        strobe,
  input  logic [WakeW-1:0]  wakeDelay,
  output logic              wakeDone,
  output logic [NumMod-1:0] modClkEn,
  output logic [NumMod-1:0] modPwrEn,
  output logic [NumMod-1:0] modIso,
  output logic [NumMod-1:0] modRstN
);
  localparam int LvlW = $clog2(LVL_TOP + 1);
  localparam logic [LvlW-1:0] LvlMax = LvlW'(LVL_TOP);
  localparam logic [WakeW-1:0] WakeOne = WakeW'(1);
  localparam logic [WakeW-1:0] WakePor = WakeW'(PorWake);

  logic [WakeW-1:0] wakeCnt;
  logic [LvlW-1:0]  level;

  always_ff @(posedge clkSleep or negedge rstPorN) begin
    if (!rstPorN) begin
      wakeCnt <= WakePor;
    end else if (strobe.loadWake) begin
      wakeCnt <= (wakeDelay == '0) ? WakeOne : wakeDelay;
    end else if (strobe.countWake && wakeCnt != WakeOne) begin
      wakeCnt <= wakeCnt - WakeOne;
    end
  end

  assign wakeDone = (wakeCnt == WakeOne);

  always_ff @(posedge clkSleep or negedge rstPorN) begin
    if (!rstPorN) begin
      level <= '0;
    end else if (strobe.rampUp) begin
      if (level != LvlMax) level <= level + 1'b1;
    end else if (level != '0) begin
      level <= level - 1'b1;
    end
  end

  for (genvar m = 0; m < NumMod; m++) begin : g_mod
    assign modPwrEn[m] = (level >= LvlW'(1));
    assign modClkEn[m] = (level >= LvlW'(2));
    assign modIso[m]   = (level <  LvlW'(3));
    assign modRstN[m]  = (level == LvlMax);
  end
endmodule

// File: rtl/pwr_state_ctl.sv
module pwr_state_ctl
  import pwrctl_pkg::*;
#(
  parameter int NumMod  = 3,
  parameter int WakeW   = 16,
  parameter int PorWake = 8
) (
  input  logic              clkSleep,
  input  logic              rstPorN,
  input  logic [NumMod-1:0] sleepReq,
  input  logic [NumMod-1:0] sleepMask,
  input  logic              wakeIn,
  input  logic              hostOff,
  input  logic              powerOff,
  input  logic [WakeW-1:0]  wakeDelay,
  output logic              refClkEn,
  output logic [NumMod-1:0] modClkEn,
  output logic [NumMod-1:0] modPwrEn,
  output logic [NumMod-1:0] modIso,
  output logic [NumMod-1:0] modRstN,
  output logic [2:0]        stateCode
);
  pwrState_e  state;
  ctlStrobe_t strobe;
  logic       wakeDone;

  pwr_state_fsm #(.NumMod(NumMod)) u_fsm (
    .clkSleep (clkSleep),
    .rstPorN  (rstPorN),
    .sleepReq (sleepReq),
    .sleepMask(sleepMask),
    .wakeIn   (wakeIn),
    .hostOff  (hostOff),
    .powerOff (powerOff),
    .wakeDone (wakeDone),
    .state    (state),
    .strobe   (strobe)
  );

  pwr_domain_dp #(.NumMod(NumMod), .WakeW(WakeW), .PorWake(PorWake)) u_dp (
    .clkSleep (clkSleep),
    .rstPorN  (rstPorN),
    .strobe   (strobe),
    .wakeDelay(wakeDelay),
    .wakeDone (wakeDone),
    .modClkEn (modClkEn),
    .modPwrEn (modPwrEn),
    .modIso   (modIso),
    .modRstN  (modRstN)
  );

  assign refClkEn  = (state == ST_WAKE) || (state == ST_ON);
  assign stateCode = state;
endmodule

// File: rtl/pwr_state_ctl_chk.sv
module pwr_state_ctl_chk #(
  parameter int NumMod = 3
) (
  input logic              clkSleep,
  input logic              rstPorN,
  input logic              refClkEn,
  input logic [NumMod-1:0] modClkEn,
  input logic [NumMod-1:0] modPwrEn,
  input logic [NumMod-1:0] modIso,
  input logic [NumMod-1:0] modRstN,
  input logic [2:0]        stateCode
);
  p_refclk_low_r2: assert property (@(posedge clkSleep) disable iff (!rstPorN)
    (stateCode == 3'd0 || stateCode == 3'd1 || stateCode == 3'd2) |-> !refClkEn);

  p_iso_before_gate_r8: assert property (@(posedge clkSleep) disable iff (!rstPorN)
    $fell(modClkEn[0]) |-> (modIso[0] && $past(modIso[0])));

  p_gate_before_pwroff_r8: assert property (@(posedge clkSleep) disable iff (!rstPorN)
    $fell(modPwrEn[0]) |-> !$past(modClkEn[0]));

  p_rst_after_iso_r9: assert property (@(posedge clkSleep) disable iff (!rstPorN)
    $rose(modRstN[0]) |-> !$past(modIso[0]));

  p_on_via_wake_r5: assert property (@(posedge clkSleep) disable iff (!rstPorN)
    (stateCode == 3'd4 && $past(stateCode) != 3'd4) |-> $past(stateCode) == 3'd3);

  p_off_sticky_r7: assert property (@(posedge clkSleep) disable iff (!rstPorN)
    ($past(stateCode) == 3'd0) |-> stateCode == 3'd0);
endmodule

bind pwr_state_ctl pwr_state_ctl_chk #(.NumMod(NumMod)) u_chk (
  .clkSleep (clkSleep),
  .rstPorN  (rstPorN),
  .refClkEn (refClkEn),
  .modClkEn (modClkEn),
  .modPwrEn (modPwrEn),
  .modIso   (modIso),
  .modRstN  (modRstN),
  .stateCode(stateCode)
);

// File: tb/sim_pwr_state_ctl.sv
`timescale 1ns/1ps
module sim_pwr_state_ctl;
  localparam int NM  = 3;
  localparam int WW  = 16;
  localparam int POR = 8;

  logic clk = 1'b0;
  logic rstPorN = 1'b0;
  logic [NM-1:0] sleepReq = '0;
  logic [NM-1:0] sleepMask = '0;
  logic wakeIn = 1'b0, hostOff = 1'b0, powerOff = 1'b0;
  logic [WW-1:0] wakeDelay = 16'd4;
  logic refClkEn;
  logic [NM-1:0] modClkEn, modPwrEn, modIso, modRstN;
  logic [2:0] stateCode;

  int vectors = 0;
  int misses = 0;
  string tag = "R1";
  bit finished = 1'b0;

  // behavioural reference
  int mState, mCnt, mLvl, nxt, oldS;
  bit allS;

  always #4 clk = ~clk;

  pwr_state_ctl #(.NumMod(NM), .WakeW(WW), .PorWake(POR)) u0 (
    .clkSleep(clk), .rstPorN(rstPorN), .sleepReq(sleepReq), .sleepMask(sleepMask),
    .wakeIn(wakeIn), .hostOff(hostOff), .powerOff(powerOff), .wakeDelay(wakeDelay),
    .refClkEn(refClkEn), .modClkEn(modClkEn), .modPwrEn(modPwrEn), .modIso(modIso),
    .modRstN(modRstN), .stateCode(stateCode)
  );

  always @(posedge clk or negedge rstPorN) begin
    if (!rstPorN) begin
      mState = 3; mCnt = POR; mLvl = 0;
    end else begin
      oldS = mState;
      allS = ((sleepReq | sleepMask) == {NM{1'b1}});
      nxt = oldS;
      if (powerOff) nxt = 0;
      else if (hostOff && oldS != 0) nxt = 1;
      else if (oldS == 1) nxt = 3;
      else if (oldS == 2 && (!allS || wakeIn)) nxt = 3;
      else if (oldS == 3 && mCnt == 1) nxt = 4;
      else if (oldS == 4 && allS && !wakeIn) nxt = 2;
      if (nxt == 3 && oldS != 3) mCnt = (wakeDelay == 0) ? 1 : int'(wakeDelay);
      else if (oldS == 3 && mCnt != 1) mCnt = mCnt - 1;
      if (oldS == 4) begin
        if (mLvl < 4) mLvl = mLvl + 1;
      end else if (mLvl > 0) begin
        mLvl = mLvl - 1;
      end
      mState = nxt;
    end
  end

  function automatic logic [NM-1:0] rep(input bit b);
    return b ? {NM{1'b1}} : {NM{1'b0}};
  endfunction

  task automatic compare();
    logic [2:0] eState;
    logic eRef;
    logic [NM-1:0] ePwr, eClk, eIso, eRst;
    bit bad;
    eState = 3'(mState);
    eRef = (mState == 3 || mState == 4);
    ePwr = rep(mLvl >= 1);
    eClk = rep(mLvl >= 2);
    eIso = rep(mLvl < 3);
    eRst = rep(mLvl == 4);
    bad = 1'b0;
    vectors++;
    if (stateCode !== eState) begin
      $display("FAIL %s stateCode got %0d exp %0d", tag, stateCode, eState); bad = 1'b1;
    end
    if (refClkEn !== eRef) begin
      $display("FAIL %s refClkEn got %0b exp %0b", tag, refClkEn, eRef); bad = 1'b1;
    end
    if (modPwrEn !== ePwr || modClkEn !== eClk || modIso !== eIso || modRstN !== eRst) begin
      $display("FAIL %s domain pwr/clk/iso/rst got %b/%b/%b/%b exp %b/%b/%b/%b",
               tag, modPwrEn, modClkEn, modIso, modRstN, ePwr, eClk, eIso, eRst);
      bad = 1'b1;
    end
    if (bad) misses++;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
    end
  endtask

  initial begin
    tag = "R1";  tick(3);                 // reset state: WAKEUP, domain off
    rstPorN = 1'b1; tick(10);             // POR wake length then ON
    tag = "R9";  tick(6);                 // ramp up in order
    tag = "R3";  sleepMask = 3'b100; sleepReq = 3'b011; tick(2);
    tag = "R8";  tick(6);                 // ramp down in order
    tag = "R2";  sleepReq = 3'b111; tick(1);
    tag = "R3";  sleepReq = 3'b011; tick(2);  // masked bit ignored in SLEEP
    tag = "R4";  wakeDelay = 16'd5; sleepReq = 3'b010; tick(2);
    tag = "R5";  tick(10);                // 5-cycle wake then ramp
    tag = "R3";  wakeIn = 1'b1; sleepReq = 3'b011; tick(3);  // wake blocks sleep
    wakeIn = 1'b0; wakeDelay = 16'd0; tick(4);
    tag = "R5";  wakeIn = 1'b1; tick(3);  // zero delay behaves as one
    wakeIn = 1'b0; sleepReq = 3'b000; tick(6);
    tag = "R6";  hostOff = 1'b1; tick(5);
    wakeDelay = 16'd2; hostOff = 1'b0; tick(8);
    tag = "R7";  hostOff = 1'b1; powerOff = 1'b1; tick(3);
    powerOff = 1'b0; tick(2);
    hostOff = 1'b0; wakeIn = 1'b1; tick(4);
    wakeIn = 1'b0;
    tag = "R1";  rstPorN = 1'b0; tick(1);
    rstPorN = 1'b1; tick(14);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired got hang exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule